// File: doc/BRIEF.md
# Timed Serial Driver Load Controller

This block sits on the host side of a chain of serial-input, latched power drivers. One start request loads a parallel word of eight bits per chained device. The block then produces the serial data, shift clock, strobe and blanking-enable waveforms for the chain. Every edge it places comes from a cycle counter for one interval. Each interval length is worked out at elaboration from a nanosecond minimum and the system clock period. The setup, hold, clock high and low widths, the clock-to-strobe gap and the strobe width therefore all meet their minimums, whatever the clock frequency.

Bits leave the block most-significant first. The chain is modelled as one long shift path whose first stage sits nearest the controller. After a complete load, word bit k therefore lands on driver channel k: channel k%8 of device k/8, where device 0 is the nearest. The block holds busy for the whole load. After the strobe it waits a settle interval that covers the drivers' output delay, then pulses done for one cycle. When blanking is requested with the start, the enable line holds all driver outputs off while the new data ripples through the chain.

Top module: `serial_load_ctrl`

## Requirements
- R1: While reset is asserted, and once it is released, the data, clock, strobe, enable, busy and done outputs are all low. Asserting reset in the middle of a load returns the block to idle at once.
- R2: A load produces exactly 8×CHAIN_LEN rising clock edges and sends the word most-significant bit first. With the chain shifting toward higher channel numbers on each rising edge, word bit k ends on channel k.
- R3: Serial data is stable for at least SETUP_NS before each rising clock edge, and stays stable for at least HOLD_NS after it.
- R4: The shift clock stays high for at least CLK_WIDTH_NS on each pulse, and stays low for at least CLK_WIDTH_NS before each rising edge.
- R5: The strobe rises no sooner than CLK_TO_STB_NS after the last rising clock edge, and stays high for at least STB_WIDTH_NS. Strobe and clock are never high together.
- R6: Done is a single-cycle pulse. It comes after the strobe has fallen, in a cycle that begins at least SETTLE_NS after the strobe rose. Busy is low in the next cycle.
- R7: Busy is high from the cycle after a start is accepted, through the done cycle.
- R8: A start request while busy is ignored. The word and blanking choice are captured when a start is accepted, so later changes on those inputs do not affect the load.
- R9: With blanking captured as 1, enable is high from the first data bit until the strobe falls, covering every clock pulse and the strobe. With blanking captured as 0, enable stays low.
- R10: When idle, the clock, strobe and enable outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Load request, accepted only when idle |
| word_i | input | 8*CHAIN_LEN | Word to load; bit k drives channel k |
| blank_i | input | 1 | 1 = hold driver outputs off during the load |
| ser_data_o | output | 1 | Serial data to the first device |
| shift_clk_o | output | 1 | Shift clock, idles low, data taken on the rising edge |
| strobe_o | output | 1 | Latch strobe, active high, idles low |
| enable_o | output | 1 | Output blanking, high = driver outputs off |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle pulse when the load and settle time are complete |

## Verification
The timing assertions measure each interval with saturating cycle counters that start at reset. They therefore take for granted that reset has been released for longer than the longest interval before the first load. They also take for granted that nothing outside the block moves the data or clock lines. The stimulus drives start, word and blank only at mid-cycle and releases reset well before the first request. It also changes word and blank right after every accepted start and fires an extra start mid-load, so that only the captured values can explain the channel outputs seen in the bench's chain model.

// File: rtl/sdl_pkg.sv
`timescale 1ns/1ps
package sdl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_GAP,
    ST_STROBE,
    ST_SETTLE
  } sdl_state_e;

  // cycles covering a nanosecond minimum, never fewer than one
  function automatic int ns_to_cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdl_timer.sv
`timescale 1ns/1ps
module sdl_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) cnt_d = val_i;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdl_shifter.sv
`timescale 1ns/1ps
module sdl_shifter #(
  parameter int NB = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic          shift_i,
  input  logic [NB-1:0] word_i,
  output logic          msb_o,
  output logic          last_o
);

  localparam int CW = (NB > 1) ? $clog2(NB) : 1;

  logic [NB-1:0] sh_q, sh_d;
  logic [CW-1:0] left_q, left_d;
  logic          sh_en;

  assign sh_en = cap_i | shift_i;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (cap_i) begin
      sh_d   = word_i;
      left_d = CW'(NB - 1);
    end else if (shift_i) begin
      sh_d   = {sh_q[NB-2:0], 1'b0};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (sh_en) begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  assign msb_o  = sh_q[NB-1];
  assign last_o = (left_q == '0);

endmodule

// File: rtl/serial_load_ctrl.sv
`timescale 1ns/1ps
module serial_load_ctrl
  import sdl_pkg::*;
#(
  parameter int CHAIN_LEN     = 2,
  parameter int CLK_PERIOD_NS = 5,
  parameter int SETUP_NS      = 75,
  parameter int HOLD_NS       = 75,
  parameter int CLK_WIDTH_NS  = 150,
  parameter int CLK_TO_STB_NS = 300,
  parameter int STB_WIDTH_NS  = 100,
  parameter int SETTLE_NS     = 500
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [8*CHAIN_LEN-1:0] word_i,
  input  logic                   blank_i,
  output logic                   ser_data_o,
  output logic                   shift_clk_o,
  output logic                   strobe_o,
  output logic                   enable_o,
  output logic                   busy_o,
  output logic                   done_o
);

  localparam int NB       = 8 * CHAIN_LEN;
  localparam int CYC_SU   = ns_to_cyc(SETUP_NS, CLK_PERIOD_NS);
  localparam int CYC_HOLD = ns_to_cyc(HOLD_NS, CLK_PERIOD_NS);
  localparam int CYC_CW   = ns_to_cyc(CLK_WIDTH_NS, CLK_PERIOD_NS);
  localparam int CYC_C2S  = ns_to_cyc(CLK_TO_STB_NS, CLK_PERIOD_NS);
  localparam int CYC_STB  = ns_to_cyc(STB_WIDTH_NS, CLK_PERIOD_NS);
  localparam int CYC_SET  = ns_to_cyc(SETTLE_NS, CLK_PERIOD_NS);
  localparam int LEN_SU   = imax(CYC_SU, CYC_CW);
  localparam int LEN_HI   = imax(CYC_CW, CYC_HOLD);
  localparam int LEN_GAP  = imax(CYC_C2S - LEN_HI, 1);
  localparam int LEN_MAX  = imax(imax(LEN_SU, LEN_HI), imax(imax(LEN_GAP, CYC_STB), CYC_SET));
  localparam int TW       = $clog2(LEN_MAX + 1);
  localparam int AW       = TW + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  sdl_state_e     st_q, st_d;
  logic           ld, tmr_zero, cap, shift, msb, last_bit;
  logic [TW-1:0]  ld_val;
  logic           blank_q;

  sdl_timer #(.W(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sn),
    .load_i (ld),
    .val_i  (ld_val),
    .zero_o (tmr_zero)
  );

  sdl_shifter #(.NB(NB)) u_shift (
    .clk     (clk),
    .rst_n   (rst_sn),
    .cap_i   (cap),
    .shift_i (shift),
    .word_i  (word_i),
    .msb_o   (msb),
    .last_o  (last_bit)
  );

  // next-state decode
  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    cap    = 1'b0;
    shift  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d = ST_SETUP; ld = 1'b1; ld_val = TW'(LEN_SU - 1); cap = 1'b1;
      end
      ST_SETUP: if (tmr_zero) begin
        st_d = ST_HIGH; ld = 1'b1; ld_val = TW'(LEN_HI - 1);
      end
      ST_HIGH: if (tmr_zero) begin
        if (last_bit) begin
          st_d = ST_GAP; ld = 1'b1; ld_val = TW'(LEN_GAP - 1);
        end else begin
          st_d = ST_SETUP; ld = 1'b1; ld_val = TW'(LEN_SU - 1); shift = 1'b1;
        end
      end
      ST_GAP: if (tmr_zero) begin
        st_d = ST_STROBE; ld = 1'b1; ld_val = TW'(CYC_STB - 1);
      end
      ST_STROBE: if (tmr_zero) begin
        st_d = ST_SETTLE; ld = 1'b1; ld_val = TW'(CYC_SET - 1);
      end
      ST_SETTLE: if (tmr_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)  blank_q <= 1'b0;
    else if (cap) blank_q <= blank_i;
  end

  assign shift_clk_o = (st_q == ST_HIGH);
  assign strobe_o    = (st_q == ST_STROBE);
  assign ser_data_o  = ((st_q == ST_SETUP) || (st_q == ST_HIGH)) ? msb : 1'b0;
  assign enable_o    = blank_q & ((st_q == ST_SETUP) || (st_q == ST_HIGH) ||
                                  (st_q == ST_GAP)   || (st_q == ST_STROBE));
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_SETTLE) && tmr_zero;

  // ---------------- interval observers for the assertions ----------------
  function automatic logic [AW-1:0] sat_inc(input logic [AW-1:0] x);
    return (x == '1) ? x : x + 1'b1;
  endfunction

  logic          clk_d, dat_d;
  logic [AW-1:0] hi_run, lo_run, dat_age, rise_age, stb_run;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      clk_d    <= 1'b0;
      dat_d    <= 1'b0;
      hi_run   <= '0;
      lo_run   <= '1;
      dat_age  <= '1;
      rise_age <= '1;
      stb_run  <= '0;
    end else begin
      clk_d    <= shift_clk_o;
      dat_d    <= ser_data_o;
      hi_run   <= shift_clk_o ? sat_inc(hi_run) : '0;
      lo_run   <= shift_clk_o ? '0 : sat_inc(lo_run);
      dat_age  <= (ser_data_o != dat_d) ? AW'(1) : sat_inc(dat_age);
      rise_age <= (shift_clk_o && !clk_d) ? AW'(1) : sat_inc(rise_age);
      stb_run  <= strobe_o ? sat_inc(stb_run) : '0;
    end
  end

  // R4
  clk_high_width_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(shift_clk_o) |-> hi_run >= AW'(CYC_CW));
  // R4
  clk_low_width_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(shift_clk_o) |-> lo_run >= AW'(CYC_CW));
  // R3
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(shift_clk_o) |-> dat_age >= AW'(CYC_SU));
  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    shift_clk_o |-> $stable(ser_data_o));
  // R5
  clk_to_strobe_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(strobe_o) |-> rise_age >= AW'(CYC_C2S));
  // R5
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(strobe_o) |-> stb_run >= AW'(CYC_STB));
  // R5
  strobe_clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    strobe_o |-> !shift_clk_o);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    done_o |=> (!done_o && !busy_o));
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy_o && !done_o) |=> busy_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !busy_o |-> (!enable_o && !shift_clk_o && !strobe_o));

endmodule

// File: tb/serial_load_ctrl_test.sv
`timescale 1ns/1ps
module serial_load_ctrl_test;

  localparam int CHAIN = 2;
  localparam int NB    = 8 * CHAIN;
  localparam int PER   = 5;

  // {blank, word}
  localparam logic [NB:0] VEC [6] = '{
    17'h0_0001, 17'h1_8000, 17'h0_A5C3, 17'h1_FFFF, 17'h0_0000, 17'h1_1234
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic blank_i = 1'b0;
  logic [NB-1:0] word_i = '0;
  logic ser_data_o, shift_clk_o, strobe_o, enable_o, busy_o, done_o;

  serial_load_ctrl #(.CHAIN_LEN(CHAIN), .CLK_PERIOD_NS(PER)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i),
    .blank_i(blank_i), .ser_data_o(ser_data_o), .shift_clk_o(shift_clk_o),
    .strobe_o(strobe_o), .enable_o(enable_o), .busy_o(busy_o), .done_o(done_o)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------- driver-chain model and timing monitor ----------
  logic pc = 1'b0, pd = 1'b0, ps = 1'b0;
  int hi_c = 0, lo_c = 1000000, dat_age = 1000000, rise_age = 1000000;
  int stb_c = 0, stb_age = 1000000;
  int viol = 0, rises = 0, dones = 0, done_age = 0, en_bad = 0;
  logic done_stb = 1'b0;
  logic cur_blank = 1'b0;
  logic [NB-1:0] sr = '0, lat = '0;
  logic [NB-1:0] drv;
  assign drv = enable_o ? '0 : lat;

  always @(negedge clk) begin
    if (!rst_n) begin
      pc = 1'b0; pd = 1'b0; ps = 1'b0; hi_c = 0;
    end else begin
      bit rise, fall, dchg, srise, sfall;
      rise  = shift_clk_o && !pc;
      fall  = !shift_clk_o && pc;
      dchg  = (ser_data_o != pd);
      srise = strobe_o && !ps;
      sfall = !strobe_o && ps;
      if (rise) begin
        if (dat_age * PER < 75 || lo_c * PER < 150) viol++;
        rises++;
        sr = {sr[NB-2:0], ser_data_o};
      end
      if (fall && hi_c * PER < 150) viol++;
      if (dchg && rise_age * PER < 75) viol++;
      if (srise && rise_age * PER < 300) viol++;
      if (sfall && stb_c * PER < 100) viol++;
      if (strobe_o && shift_clk_o) viol++;
      if (strobe_o) lat = sr;
      if (done_o) begin dones++; done_age = stb_age; done_stb = strobe_o; end
      if (cur_blank ? (busy_o && (shift_clk_o || strobe_o) && !enable_o) : enable_o) en_bad++;
      hi_c     = shift_clk_o ? hi_c + 1 : 0;
      lo_c     = shift_clk_o ? 0 : lo_c + 1;
      dat_age  = dchg ? 1 : dat_age + 1;
      rise_age = rise ? 1 : rise_age + 1;
      stb_c    = strobe_o ? stb_c + 1 : 0;
      stb_age  = srise ? 1 : stb_age + 1;
      pc = shift_clk_o; pd = ser_data_o; ps = strobe_o;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic do_load(input logic [NB-1:0] w, input bit b, input bit intrude);
    int v0, guard;
    bit seen;
    step();
    v0 = viol; rises = 0; dones = 0; en_bad = 0; cur_blank = b;
    word_i = w; blank_i = b; start_i = 1'b1;
    step();
    start_i = 1'b0; word_i = ~w; blank_i = !b;   // R8: later input changes must not matter
    chk(busy_o == 1'b1, "R7 busy after start", busy_o, 1);
    chk(enable_o == b, "R9 enable at first bit", enable_o, b);
    guard = 0; seen = 0;
    while (!seen && guard < 5000) begin
      if (intrude && guard == 300) begin start_i = 1'b1; word_i = w ^ 16'h5A5A; end
      if (intrude && guard == 301) start_i = 1'b0;
      if (done_o) begin
        seen = 1;
        chk(busy_o == 1'b1, "R7 busy in done cycle", busy_o, 1);
      end
      step();
      guard++;
    end
    if (!seen) chk(1'b0, "watchdog: no done", guard, 0);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R6 done single, busy low after", {done_o, busy_o}, 0);
    chk(dones == 1, "R6 done pulse count", dones, 1);
    chk(done_age * PER >= 500 && done_stb == 1'b0, "R6 settle after strobe", done_age * PER, 500);
    chk(rises == NB, "R2 rising edge count", rises, NB);
    chk(drv == w, "R2 R8 channel outputs", drv, w);
    chk(viol == v0, "R3 R4 R5 timing violations", viol - v0, 0);
    chk(en_bad == 0, "R9 blanking pattern", en_bad, 0);
    chk(!enable_o && !shift_clk_o && !strobe_o, "R10 idle levels",
        {enable_o, shift_clk_o, strobe_o}, 0);
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog: run timeout", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (4) step();
    chk({ser_data_o, shift_clk_o, strobe_o, enable_o, busy_o, done_o} == 6'b0,
        "R1 outputs in reset", {ser_data_o, shift_clk_o, strobe_o, enable_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (4) step();
    chk({ser_data_o, shift_clk_o, strobe_o, enable_o, busy_o, done_o} == 6'b0,
        "R1 outputs after release", {ser_data_o, shift_clk_o, strobe_o, enable_o, busy_o, done_o}, 0);

    // vector table
    for (int i = 0; i < 6; i++) do_load(VEC[i][NB-1:0], VEC[i][NB], 1'b0);

    // R8: start while busy ignored, with and without blanking
    do_load(16'h3C96, 1'b0, 1'b1);
    do_load(16'h0F0F, 1'b1, 1'b1);

    // R1: reset in the middle of a load
    step();
    word_i = 16'hFFFF; blank_i = 1'b1; start_i = 1'b1;
    step();
    start_i = 1'b0;
    repeat (100) step();
    chk(busy_o == 1'b1, "R7 busy mid-load", busy_o, 1);
    rst_n = 1'b0;
    step();
    chk({ser_data_o, shift_clk_o, strobe_o, enable_o, busy_o, done_o} == 6'b0,
        "R1 mid-load reset", {ser_data_o, shift_clk_o, strobe_o, enable_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (4) step();

    // recovery after reset
    do_load(16'hC001, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule